// File: doc/BRIEF.md
# Pre-encoded Signed-Digit Multiply-Accumulate Unit

This block multiplies a two's complement multiplicand by a coefficient held in an internal read-only table and adds the product into a double-width accumulator. Each coefficient is stored already recoded into radix-4 signed digits. Every digit except the most significant one takes 2 bits and one of four values. The top digit takes 3 bits and one of five values. Because no recoding happens on line, each digit drives one partial product through a shift, double and negate selector. An n-bit coefficient therefore gives exactly n/2 partial products.

The partial products, plus one word that carries the negation corrections, go through a carry-save chain down to a sum word and a carry word. A final adder joins the two words, and the result is either added into the accumulator or loaded into it. The datapath has three register stages: table read, selection and compression, then final add and accumulate. A valid bit moves through the stages with the data. The unit takes one operation on every cycle and has no back-pressure: no ready signal exists, and every cycle with `in_valid` high is accepted. A parameter chooses the digit set. The minus set covers -2..+1 and the plus set covers -1..+2. The two sets give identical arithmetic results.

Top module: `sd_mac`

## Requirements
- R1: Synchronous reset `rst`. On the first rising edge with `rst` high, `acc_out` becomes 0 and `acc_valid` becomes 0, and both stay so while `rst` is held.
- R2: An operation accepted on rising edge k (`in_valid` high) changes `acc_out` on edge k+2 and raises `acc_valid` for exactly the one cycle after that edge. `acc_valid` is low at all other times.
- R3: With `in_clear` low, an accepted operation leaves `acc_out` = previous `acc_out` + coef(`in_addr`) × `in_mcand`, wrapped modulo 2^(MCAND_W+COEF_W).
- R4: With `in_clear` high, an accepted operation loads `acc_out` with coef(`in_addr`) × `in_mcand` and discards the previous sum.
- R5: A cycle with `in_valid` low is ignored whatever `in_clear`, `in_addr` and `in_mcand` carry: `acc_out` keeps its value and `acc_valid` stays low.
- R6: Table entry a holds coef(a) = (73·a + 2^(COEF_W-1)) mod 2^COEF_W, read as two's complement. It is stored as COEF_W/2 digits of weight 4^j. Digit j < COEF_W/2-1 sits in word bits [2j+1:2j]. The top digit sits in the upper 3 bits as a two's complement value in -2..+2.
- R7: Minus set (PLUS=0): lower digit codes are 00=0, 01=+1, 10=-2, 11=-1.
- R8: Plus set (PLUS=1): lower digit codes are 00=0, 01=+1, 10=+2, 11=-1. For every operation sequence it gives the same `acc_out` as the minus set.
- R9: Exactly one partial product is formed per digit. The products are exact at the operand extremes, including -128 × -128 = 16384 and 127 × 127 = 16129 with the default widths.
- R10: Operations on consecutive cycles are all accepted. Each produces its own `acc_valid` pulse and its own accumulator update, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_clear | input | 1 | Load the product instead of adding it |
| in_mcand | input | MCAND_W | Two's complement multiplicand |
| in_addr | input | $clog2(DEPTH) | Coefficient table address |
| acc_valid | output | 1 | One-cycle pulse when the accumulator has been updated |
| acc_out | output | MCAND_W+COEF_W | Accumulator contents |

## Verification
The main path is driven with coefficients whose digit strings propagate a carry across every digit (127, 91) and with coefficients that end in a lone negative top digit (-128, -55). These are paired with the multiplicands -128, 127, -1, 0 and small values. Together they separate a wrong digit code, a lost negation correction and a missing sign extension. Load and add cycles are interleaved, and one pair of additions overflows the accumulator, to show the clear path and the wrap apart. A burst on four consecutive cycles, a run of ignored cycles with clear asserted, and a reset in mid-run expose valid-bit slips. Both digit sets run side by side on the same stimulus, so a decode error in only one set shows up as a mismatch.

// File: rtl/sd_mac_pkg.sv
`timescale 1ns/1ps
package sd_mac_pkg;

  // Magnitude chosen for one partial product
  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } mag_e;

  typedef struct packed {
    mag_e mag;
    logic neg;
  } digit_sel_t;

  // Step of the coefficient table contents
  localparam int COEF_STEP = 73;

  function automatic int coef_raw(input int addr, input int coef_w);
    return addr * COEF_STEP + (1 << (coef_w - 1));
  endfunction

  // Turn a stored digit code into a selector; top digit is 3-bit two's complement
  function automatic digit_sel_t decode_digit(input logic [2:0] code,
                                              input bit is_top,
                                              input bit plus_set);
    digit_sel_t d;
    d.mag = MAG_ZERO;
    d.neg = 1'b0;
    if (is_top) begin
      case (code)
        3'b001:  d.mag = MAG_ONE;
        3'b010:  d.mag = MAG_TWO;
        3'b110:  begin d.mag = MAG_TWO; d.neg = 1'b1; end
        3'b111:  begin d.mag = MAG_ONE; d.neg = 1'b1; end
        default: d.mag = MAG_ZERO;
      endcase
    end else begin
      case (code[1:0])
        2'b01:   d.mag = MAG_ONE;
        2'b10:   begin d.mag = MAG_TWO; d.neg = !plus_set; end
        2'b11:   begin d.mag = MAG_ONE; d.neg = 1'b1; end
        default: d.mag = MAG_ZERO;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/sd_mac_coef_rom.sv
`timescale 1ns/1ps
module sd_mac_coef_rom #(
  parameter int COEF_W = 8,
  parameter int DEPTH  = 16,
  parameter bit PLUS   = 1'b0,
  localparam int ND     = COEF_W / 2,
  localparam int WORD_W = COEF_W + 1,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word_q
);

  // Recode one coefficient into signed digits, least significant first
  function automatic logic [WORD_W-1:0] encode_coef(input logic [COEF_W-1:0] b);
    logic [WORD_W-1:0] w;
    int t;
    int c;
    int d;
    int top;
    w = '0;
    c = 0;
    for (int j = 0; j < ND - 1; j++) begin
      t = int'(b[2*j +: 2]) + c;
      if (PLUS) begin
        case (t)
          0:       begin d = 0;  c = 0; end
          1:       begin d = 1;  c = 0; end
          2:       begin d = 2;  c = 0; end
          3:       begin d = -1; c = 1; end
          default: begin d = 0;  c = 1; end
        endcase
      end else begin
        case (t)
          0:       begin d = 0;  c = 0; end
          1:       begin d = 1;  c = 0; end
          2:       begin d = -2; c = 1; end
          3:       begin d = -1; c = 1; end
          default: begin d = 0;  c = 1; end
        endcase
      end
      w[2*j +: 2] = d[1:0];
    end
    top = c + int'(b[COEF_W-2]) - 2 * int'(b[COEF_W-1]);
    w[WORD_W-1 -: 3] = top[2:0];
    return w;
  endfunction

  function automatic logic [DEPTH*WORD_W-1:0] build_image();
    logic [DEPTH*WORD_W-1:0] img;
    logic [COEF_W-1:0] b;
    int v;
    img = '0;
    for (int a = 0; a < DEPTH; a++) begin
      v = sd_mac_pkg::coef_raw(a, COEF_W);
      b = v[COEF_W-1:0];
      img[a*WORD_W +: WORD_W] = encode_coef(b);
    end
    return img;
  endfunction

  localparam logic [DEPTH*WORD_W-1:0] IMAGE = build_image();

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= IMAGE[int'(addr)*WORD_W +: WORD_W];
  end

  logic [2:0] top_code;
  assign top_code = word_q[WORD_W-1 -: 3];

  AST_TOP_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    !(top_code == 3'b011 || top_code == 3'b100 || top_code == 3'b101)); // R6

endmodule

// File: rtl/sd_mac_pp_gen.sv
`timescale 1ns/1ps
module sd_mac_pp_gen
  import sd_mac_pkg::*;
#(
  parameter int MCAND_W = 8,
  parameter int ACC_W   = 16,
  parameter int SHIFT   = 0,
  parameter int CODE_W  = 2,
  parameter bit IS_TOP  = 1'b0,
  parameter bit PLUS    = 1'b0
) (
  input  logic [MCAND_W-1:0] mcand,
  input  logic [CODE_W-1:0]  code,
  output logic [ACC_W-1:0]   pp,
  output logic               neg
);

  digit_sel_t sel;
  logic [ACC_W-1:0] xs;
  logic [ACC_W-1:0] mag_v;
  logic [ACC_W-1:0] inv_v;

  assign sel = decode_digit(3'(code), IS_TOP, PLUS);
  assign xs  = ACC_W'($signed(mcand));

  always_comb begin
    case (sel.mag)
      MAG_ONE: mag_v = xs;
      MAG_TWO: mag_v = xs << 1;
      default: mag_v = '0;
    endcase
  end

  // Negate as one's complement; the +1 at weight 4^j is added by the tree
  assign inv_v = sel.neg ? ~mag_v : mag_v;
  assign pp    = inv_v << SHIFT;
  assign neg   = sel.neg;

endmodule

// File: rtl/sd_mac_csa_tree.sv
`timescale 1ns/1ps
module sd_mac_csa_tree #(
  parameter int W    = 16,
  parameter int NOPS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ops [NOPS],
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  logic [W-1:0] s_ch [NOPS-1];
  logic [W-1:0] c_ch [NOPS-1];

  assign s_ch[0] = ops[0];
  assign c_ch[0] = ops[1];

  for (genvar k = 0; k < NOPS - 2; k++) begin : g_csa
    assign s_ch[k+1] = s_ch[k] ^ c_ch[k] ^ ops[k+2];
    assign c_ch[k+1] = ((s_ch[k] & c_ch[k]) | (s_ch[k] & ops[k+2]) |
                        (c_ch[k] & ops[k+2])) << 1;
  end

  assign sum   = s_ch[NOPS-2];
  assign carry = c_ch[NOPS-2];

  logic [W-1:0] ref_total;
  logic [W-1:0] tree_total;
  always_comb begin
    ref_total = '0;
    for (int i = 0; i < NOPS; i++) ref_total = ref_total + ops[i];
  end
  assign tree_total = sum + carry;

  AST_TREE_PRESERVES_SUM: assert property (@(posedge clk) disable iff (rst)
    tree_total == ref_total); // R9

endmodule

// File: rtl/sd_mac.sv
`timescale 1ns/1ps
module sd_mac #(
  parameter int MCAND_W = 8,
  parameter int COEF_W  = 8,
  parameter int DEPTH   = 16,
  parameter bit PLUS    = 1'b0,
  localparam int ACC_W  = MCAND_W + COEF_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_clear,
  input  logic [MCAND_W-1:0] in_mcand,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               acc_valid,
  output logic [ACC_W-1:0]   acc_out
);

  localparam int ND     = COEF_W / 2;
  localparam int WORD_W = COEF_W + 1;
  localparam int NOPS   = ND + 1;

  // Stage A: table read
  logic [WORD_W-1:0]  word_a;
  logic [MCAND_W-1:0] x_a;
  logic               v_a;
  logic               clr_a;

  sd_mac_coef_rom #(.COEF_W(COEF_W), .DEPTH(DEPTH), .PLUS(PLUS)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr   (in_addr),
    .word_q (word_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_a   <= '0;
      v_a   <= 1'b0;
      clr_a <= 1'b0;
    end else begin
      x_a   <= in_mcand;
      v_a   <= in_valid;
      clr_a <= in_clear;
    end
  end

  // Stage B: partial product selection and carry-save reduction
  logic [ACC_W-1:0] pp_v [ND];
  logic [ND-1:0]    neg_v;
  logic [ACC_W-1:0] corr_word;
  logic [ACC_W-1:0] ops [NOPS];
  logic [ACC_W-1:0] tree_s;
  logic [ACC_W-1:0] tree_c;

  for (genvar j = 0; j < ND; j++) begin : g_digit
    if (j == ND - 1) begin : g_top
      sd_mac_pp_gen #(
        .MCAND_W(MCAND_W), .ACC_W(ACC_W), .SHIFT(2*j),
        .CODE_W(3), .IS_TOP(1'b1), .PLUS(PLUS)
      ) u_pp (
        .mcand (x_a),
        .code  (word_a[WORD_W-1 -: 3]),
        .pp    (pp_v[j]),
        .neg   (neg_v[j])
      );
    end else begin : g_low
      sd_mac_pp_gen #(
        .MCAND_W(MCAND_W), .ACC_W(ACC_W), .SHIFT(2*j),
        .CODE_W(2), .IS_TOP(1'b0), .PLUS(PLUS)
      ) u_pp (
        .mcand (x_a),
        .code  (word_a[2*j +: 2]),
        .pp    (pp_v[j]),
        .neg   (neg_v[j])
      );
    end
  end

  always_comb begin
    corr_word = '0;
    for (int j = 0; j < ND; j++) corr_word[2*j] = neg_v[j];
    for (int j = 0; j < ND; j++) ops[j] = pp_v[j];
    ops[ND] = corr_word;
  end

  sd_mac_csa_tree #(.W(ACC_W), .NOPS(NOPS)) u_tree (
    .clk   (clk),
    .rst   (rst),
    .ops   (ops),
    .sum   (tree_s),
    .carry (tree_c)
  );

  logic [ACC_W-1:0] s_b;
  logic [ACC_W-1:0] c_b;
  logic             v_b;
  logic             clr_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_b   <= '0;
      c_b   <= '0;
      v_b   <= 1'b0;
      clr_b <= 1'b0;
    end else begin
      s_b   <= tree_s;
      c_b   <= tree_c;
      v_b   <= v_a;
      clr_b <= clr_a;
    end
  end

  // Stage C: final add and accumulate
  logic [ACC_W-1:0] prod;
  assign prod = s_b + c_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out   <= '0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= v_b;
      if (v_b) acc_out <= clr_b ? prod : acc_out + prod;
    end
  end

  // Cycles since reset, saturating, used to window the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (acc_out == '0 && !acc_valid)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (acc_valid == $past(in_valid, 3))); // R2

  AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (rst)
    (v_b && clr_b) |=> (acc_out == $past(prod))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !v_b |=> $stable(acc_out)); // R5

endmodule

// File: tb/sd_mac_tb_top.sv
`timescale 1ns/1ps
module sd_mac_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_clear = 1'b0;
  logic [7:0]  in_mcand = '0;
  logic [3:0]  in_addr = '0;
  logic        vld_m;
  logic        vld_p;
  logic [15:0] acc_m;
  logic [15:0] acc_p;

  always #5 clk = ~clk;

  sd_mac #(.MCAND_W(8), .COEF_W(8), .DEPTH(16), .PLUS(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
    .in_mcand(in_mcand), .in_addr(in_addr), .acc_valid(vld_m), .acc_out(acc_m)
  );

  sd_mac #(.MCAND_W(8), .COEF_W(8), .DEPTH(16), .PLUS(1'b1)) dut_p_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
    .in_mcand(in_mcand), .in_addr(in_addr), .acc_valid(vld_p), .acc_out(acc_p)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] model = '0;

  // Stimulus table: address, multiplicand, clear
  localparam int NV = 12;
  localparam int VA [NV] = '{0, 7, 7, 0, 2, 1, 5, 3, 4, 15, 8, 14};
  localparam int VX [NV] = '{-128, 127, 127, 127, -1, 3, 0, -86, 85, -7, 1, -128};
  localparam int VC [NV] = '{1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0};

  // R6: coefficient at address a
  function automatic int coef_ref(input int a);
    int t;
    t = (a * 73 + 128) % 256;
    if (t >= 128) t = t - 256;
    return t;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input int a, input int x, input bit clr);
    logic [15:0] p;
    p = 16'(coef_ref(a) * x);
    @(negedge clk);
    in_addr = 4'(a); in_mcand = 8'(x); in_clear = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0;
    if (clr) model = p;
    else     model = model + p;
    @(negedge clk);
    check("R2", {15'b0, vld_m}, 16'd0);
    @(negedge clk);
    check("R2", {15'b0, vld_m}, 16'd1);
    if (clr) check("R4", acc_m, model);
    else     check("R3", acc_m, model);
    check("R8", acc_p, model);
    check("R8", {15'b0, vld_p}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] exp_q [4];
    int          ba [4];
    int          bx [4];
    bit          bc [4];
    bit          expv;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", acc_m, 16'd0);
    check("R1", {15'b0, vld_m}, 16'd0);
    check("R1", acc_p, 16'd0);
    rst = 1'b0;

    // R3 R4 R6 R7 R8 R9: table walk (includes -128*-128 and an accumulator wrap)
    for (int i = 0; i < NV; i++) do_op(VA[i], VX[i], VC[i] != 0);

    // R5: invalid cycles with clear and data present are ignored
    in_valid = 1'b0; in_clear = 1'b1; in_addr = 4'd7; in_mcand = 8'd100;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5", acc_m, model);
      check("R5", {15'b0, vld_m}, 16'd0);
    end
    in_clear = 1'b0;

    // R10: four operations on consecutive cycles
    ba = '{9, 10, 13, 6}; bx = '{11, -3, 100, -128}; bc = '{1'b1, 1'b0, 1'b0, 1'b0};
    for (int k = 0; k < 4; k++) begin
      if (bc[k]) model = 16'(coef_ref(ba[k]) * bx[k]);
      else       model = model + 16'(coef_ref(ba[k]) * bx[k]);
      exp_q[k] = model;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      expv = (i >= 3 && i <= 6);
      check("R10", {15'b0, vld_m}, {15'b0, expv});
      if (expv) begin
        check("R10", acc_m, exp_q[i-3]);
        check("R10", acc_p, exp_q[i-3]);
      end
      if (i < 4) begin
        in_addr = 4'(ba[i]); in_mcand = 8'(bx[i]); in_clear = bc[i]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0; in_clear = 1'b0;
      end
    end

    // R1: reset in mid-run, then accumulate from zero
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", acc_m, 16'd0);
    check("R1", acc_p, 16'd0);
    check("R1", {15'b0, vld_m}, 16'd0);
    rst = 1'b0;
    model = '0;
    do_op(7, 2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule